// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Payload and Line Inversion

This block is a full-duplex asynchronous serial transmitter and receiver. Each frame carries a start bit, eight data bits, an optional parity bit and one or two stop bits. The data bits go out least significant first, or most significant first when the order control is set. A free-running divider produces a tick at sixteen times the bit rate. Both directions use that tick: the transmitter holds each bit for sixteen ticks, and the receiver oversamples the line.

Two inversion controls act at different layers, and either can be used without the other.
- **Payload inversion** complements only the data byte. The byte handed to the transmitter is complemented before it is serialized. The byte that was assembled from the line is complemented before it reaches the receive output. Parity always covers the data bits as they appear on the line, which means after payload inversion.
- **Line inversion** flips every level on the serial output and on the serial input. This includes the idle level and the start, parity and stop bits. It lets the block drive or accept a signal through an inverting buffer.

The receiver reports each byte with a one-cycle strobe. It also raises a parity flag and a framing flag in the same cycle as the strobe.

Top module: `uart_dual_invert`

## Requirements
- R1: After reset, `tx_busy` and `rx_valid` are low. While the transmitter is idle, `txd` is 1 when `pin_inv`=0 and 0 when `pin_inv`=1.
- R2: With `msb_first`=0 and no inversion, the line carries these bits, one per bit period of 16 ticks, in this order:
  - the start bit at level 0;
  - `tx_data[0]` through `tx_data[7]`;
  - the parity bit, if enabled;
  - the stop bit(s) at level 1.
- R3: With `msb_first`=1, `tx_data[7]` follows the start bit and `tx_data[0]` is the last data bit. The receiver undoes the same order, so the byte it outputs is the byte that was sent.
- R4: With `data_inv`=1, the transmitter sends the complement of `tx_data`. The start, parity and stop bits keep their normal levels.
- R5: With `pin_inv`=1, every level on `txd` is the complement of the level it has with `pin_inv`=0. This covers the start, data, parity and stop bits.
- R6: With `parity_en`=1, one parity bit follows the last data bit. With `parity_odd`=0, its value is the XOR of the eight line data bits (even parity). With `parity_odd`=1, its value is the complement of that XOR (odd parity).
- R7: `two_stop`=0 gives one stop bit and `two_stop`=1 gives two. `tx_busy` stays high for the frame's length in bit periods times 16 ticks, less at most one tick.
- R8: A `tx_start` pulse that arrives while `tx_busy` is high is ignored. The frame in progress and the frame count are unchanged.
- R9: The receiver pulses `rx_valid` for exactly one cycle. The pulse comes at the centre of the last stop bit, that is (8 + 16·(frame bits − 1))·DIV cycles after the start edge, plus at most DIV + 4 cycles.
- R10: With `data_inv`=1, `rx_data` is the complement of the data bits received from the line.
- R11: With `pin_inv`=1, the receiver inverts `rxd` before decoding. An inverted frame therefore yields the same byte and flags as a plain frame.
- R12: `rx_parity_err` is high with the strobe exactly when parity is enabled and the received parity bit does not match the parity computed under R6.
- R13: `rx_frame_err` is high with the strobe when any stop bit is sampled at the non-idle level.
- R14: A start-level pulse on the line that ends before mid-bit is rejected, and no byte is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_inv | input | 1 | Complement the payload on transmit and on receive |
| pin_inv | input | 1 | Invert all levels on `txd` and `rxd` |
| msb_first | input | 1 | 1 = most significant data bit first |
| parity_en | input | 1 | Add a parity bit and check it |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| two_stop | input | 1 | 1 = two stop bits |
| tx_data | input | 8 | Byte to transmit |
| tx_start | input | 1 | Start a frame; taken only while idle |
| tx_busy | output | 1 | A frame is being sent |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_parity_err | output | 1 | Parity mismatch; high only with the strobe |
| rx_frame_err | output | 1 | Stop bit at the wrong level; high only with the strobe |

## Verification

**Transmitter timing.** The transmitter starts its start bit on the first edge after `tx_start`, and the free-running tick sets where each bit boundary falls. The bench therefore reads `txd` at offsets of 8·DIV + 16·DIV·k cycles from that edge. At each such point the bit is at least 7·DIV cycles from either boundary.

**Receiver timing.** A byte is due at the centre of the last stop bit. The start edge first passes two synchronizer stages and then waits for the next tick. The bench therefore counts cycles from the start edge to the strobe and accepts a window DIV + 4 cycles wide.

**Capture.** A monitor latches each strobe and its flags on the falling edge, so a strobe is not missed while the transmitter bits are being read. Each test ends with a count of the strobes that arrived.

// File: rtl/uart_dual_invert.sv
module uart_dual_invert #(
  parameter int DIV = 4,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_inv,
  input  logic          pin_inv,
  input  logic          msb_first,
  input  logic          parity_en,
  input  logic          parity_odd,
  input  logic          two_stop,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_start,
  output logic          tx_busy,
  output logic          txd,
  input  logic          rxd,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          rx_parity_err,
  output logic          rx_frame_err
);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int FW  = DW + 4;
  localparam int LW  = $clog2(FW + 1);
  localparam int IW  = (DW > 1) ? $clog2(DW) : 1;

  logic [DCW-1:0] div_q;
  logic tick;
  assign tick = (div_q == DCW'(DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div_q <= '0;
    else        div_q <= tick ? '0 : div_q + 1'b1;

  logic [DW-1:0] tx_pay, tx_ord, rx_ord;
  logic [DW-1:0] rx_sh;
  logic tx_par;

  always_comb begin
    tx_pay = data_inv ? ~tx_data : tx_data;
    for (int i = 0; i < DW; i++) begin
      tx_ord[i] = msb_first ? tx_pay[DW-1-i] : tx_pay[i];
      rx_ord[i] = msb_first ? rx_sh[DW-1-i] : rx_sh[i];
    end
  end
  assign tx_par = parity_odd ^ (^tx_pay);

  logic [FW-1:0] tx_sh;
  logic [3:0]    tx_ph;
  logic [LW-1:0] tx_left;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_ph   <= '0;
      tx_left <= '0;
    end else if (!tx_busy) begin
      if (tx_start) begin
        tx_busy <= 1'b1;
        tx_ph   <= '0;
        tx_sh   <= {2'b11, parity_en ? tx_par : 1'b1, tx_ord, 1'b0};
        tx_left <= LW'(DW + 2) + LW'(parity_en) + LW'(two_stop);
      end
    end else if (tick) begin
      tx_ph <= tx_ph + 1'b1;
      if (tx_ph == 4'd15) begin
        tx_sh   <= {1'b1, tx_sh[FW-1:1]};
        tx_left <= tx_left - 1'b1;
        if (tx_left == LW'(1)) tx_busy <= 1'b0;
      end
    end

  assign txd = (tx_busy ? tx_sh[0] : 1'b1) ^ pin_inv;

  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP} rx_st_t;
  rx_st_t        rx_st;
  logic [1:0]    rx_sync;
  logic [3:0]    rx_ph;
  logic [IW-1:0] rx_idx;
  logic          rx_perr, rx_line;

  assign rx_line = rx_sync[1] ^ pin_inv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sync       <= 2'b11;
      rx_st         <= R_IDLE;
      rx_ph         <= '0;
      rx_idx        <= '0;
      rx_sh         <= '0;
      rx_perr       <= 1'b0;
      rx_data       <= '0;
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
    end else begin
      rx_sync       <= {rx_sync[0], rxd};
      rx_valid      <= 1'b0;
      rx_parity_err <= 1'b0;
      rx_frame_err  <= 1'b0;
      if (tick) begin
        rx_ph <= rx_ph + 1'b1;
        case (rx_st)
          R_IDLE:
            if (!rx_line) begin
              rx_st <= R_START;
              rx_ph <= '0;
            end
          R_START:
            if (rx_ph == 4'd7) begin
              rx_ph   <= '0;
              rx_idx  <= '0;
              rx_perr <= 1'b0;
              rx_st   <= rx_line ? R_IDLE : R_DATA;
            end
          R_DATA:
            if (rx_ph == 4'd15) begin
              rx_sh  <= {rx_line, rx_sh[DW-1:1]};
              rx_idx <= rx_idx + 1'b1;
              if (rx_idx == IW'(DW - 1)) begin
                rx_idx <= '0;
                rx_st  <= parity_en ? R_PAR : R_STOP;
              end
            end
          R_PAR:
            if (rx_ph == 4'd15) begin
              rx_perr <= rx_line ^ parity_odd ^ (^rx_sh);
              rx_st   <= R_STOP;
            end
          R_STOP:
            if (rx_ph == 4'd15) begin
              rx_idx <= rx_idx + 1'b1;
              if (!rx_line) rx_perr <= rx_perr;
              if (rx_idx == IW'(two_stop)) begin
                rx_st         <= R_IDLE;
                rx_valid      <= 1'b1;
                rx_data       <= data_inv ? ~rx_ord : rx_ord;
                rx_parity_err <= rx_perr;
                rx_frame_err  <= ~rx_line | rx_sh_ferr;
              end
            end
          default: rx_st <= R_IDLE;
        endcase
      end
    end

  logic rx_sh_ferr;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sh_ferr <= 1'b0;
    else if (tick && rx_st == R_START) rx_sh_ferr <= 1'b0;
    else if (tick && rx_st == R_STOP && rx_ph == 4'd15 && !rx_line) rx_sh_ferr <= 1'b1;
endmodule

module uart_dual_invert_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_inv,
  input logic parity_en,
  input logic tx_start,
  input logic tx_busy,
  input logic txd,
  input logic rx_valid,
  input logic rx_parity_err,
  input logic rx_frame_err
);
  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd == !pin_inv);
  assert_start_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> txd == pin_inv);
  assert_start_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(tx_start));
  assert_one_cycle_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_flags_with_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_parity_err || rx_frame_err) |-> rx_valid);
  assert_no_parity_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !parity_en) |-> !rx_parity_err);
endmodule

bind uart_dual_invert uart_dual_invert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_inv(pin_inv), .parity_en(parity_en),
  .tx_start(tx_start), .tx_busy(tx_busy), .txd(txd), .rx_valid(rx_valid),
  .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
);

// File: tb/sim_uart_dual_invert.sv
module sim_uart_dual_invert;
  localparam int D = 4;
  localparam int BP = 16 * D;

  logic clk = 0, rst_n = 0;
  logic data_inv = 0, pin_inv = 0, msb_first = 0, parity_en = 0, parity_odd = 0, two_stop = 0;
  logic [7:0] tx_data = 0;
  logic tx_start = 0, loop = 0, bench_rx = 1;
  logic tx_busy, txd, rx_valid, rx_parity_err, rx_frame_err;
  logic [7:0] rx_data;
  logic rxd;
  assign rxd = loop ? txd : bench_rx;

  uart_dual_invert #(.DIV(D), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .data_inv(data_inv), .pin_inv(pin_inv),
    .msb_first(msb_first), .parity_en(parity_en), .parity_odd(parity_odd),
    .two_stop(two_stop), .tx_data(tx_data), .tx_start(tx_start),
    .tx_busy(tx_busy), .txd(txd), .rxd(rxd), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, got = 0, cap_cyc = 0;
  logic [7:0] cap_data;
  logic cap_pe, cap_fe;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rx_valid) begin
    got++; cap_data = rx_data; cap_pe = rx_parity_err; cap_fe = rx_frame_err; cap_cyc = cyc;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cfg = {data_inv, pin_inv, msb_first, parity_en, parity_odd, two_stop}
  task automatic set_cfg(logic [5:0] c);
    @(negedge clk);
    {data_inv, pin_inv, msb_first, parity_en, parity_odd, two_stop} = c;
    bench_rx = ~c[4];
    repeat (2 * BP) @(negedge clk);
    got = 0;
  endtask

  function automatic int flen(logic [5:0] c);
    return 10 + int'(c[2]) + int'(c[0]);
  endfunction

  function automatic logic [11:0] fbits(logic [5:0] c, logic [7:0] x);
    logic [7:0] d = c[5] ? ~x : x;
    logic [11:0] b = '1;
    b[0] = 1'b0;
    for (int i = 0; i < 8; i++) b[i+1] = c[3] ? d[7-i] : d[i];
    if (c[2]) b[9] = c[1] ^ (^d);
    return b ^ {12{c[4]}};
  endfunction

  task automatic send_rx(logic [11:0] b, int n);
    for (int k = 0; k < n; k++) begin
      bench_rx = b[k];
      repeat ((k == n - 1) ? 12 * D : BP) @(negedge clk);
    end
    bench_rx = ~pin_inv;
    repeat (3 * BP) @(negedge clk);
  endtask

  task automatic pulse_tx(logic [7:0] x);
    @(negedge clk);
    tx_data = x; tx_start = 1;
    @(negedge clk);
    tx_start = 0;
  endtask

  localparam logic [13:0] VEC [0:7] = '{
    {6'b000000, 8'h35}, {6'b000100, 8'h35}, {6'b000110, 8'h35}, {6'b001000, 8'h01},
    {6'b100000, 8'h0F}, {6'b010100, 8'hC4}, {6'b110111, 8'h5A}, {6'b101101, 8'h80}};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int busy_n, c0, lo, hi;
    logic [11:0] fb;
    repeat (3) @(negedge clk);
    chk("R1 reset txd", txd, 1);
    chk("R1 reset busy", tx_busy, 0);
    chk("R1 reset valid", rx_valid, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 idle txd", txd, 1);
    pin_inv = 1;
    #1 chk("R1 idle inverted txd", txd, 0);

    // line checks cover R2 R3 R4 R5 R6 R7; loopback covers R3 R10 R11
    for (int v = 0; v < 8; v++) begin
      set_cfg(VEC[v][13:8]);
      loop = 1;
      fb = fbits(VEC[v][13:8], VEC[v][7:0]);
      pulse_tx(VEC[v][7:0]);
      for (int k = 0; k < flen(VEC[v][13:8]); k++) begin
        repeat ((k == 0) ? 8 * D - 1 : BP) @(negedge clk);
        chk($sformatf("R2 R3 R4 R5 R6 R7 vec%0d bit%0d", v, k), txd, fb[k]);
      end
      repeat (BP) @(negedge clk);
      chk($sformatf("R7 vec%0d idle after frame", v), tx_busy, 0);
      chk($sformatf("R9 vec%0d strobes", v), got, 1);
      chk($sformatf("R3 R10 R11 vec%0d loopback data", v), cap_data, VEC[v][7:0]);
      chk($sformatf("R12 R13 vec%0d no flags", v), {cap_pe, cap_fe}, 0);
      loop = 0;
    end

    // R7 busy length with parity and two stop bits (12 bit periods)
    set_cfg(6'b000101);
    pulse_tx(8'h3C);
    busy_n = 1;
    while (tx_busy) begin @(negedge clk); busy_n++; end
    chk("R7 busy length in range", int'(busy_n >= 12 * BP - D && busy_n <= 12 * BP + 1), 1);

    // R8 second start during a frame is ignored
    set_cfg(6'b000000);
    loop = 1;
    pulse_tx(8'h55);
    repeat (3 * BP) @(negedge clk);
    pulse_tx(8'hAA);
    repeat (10 * BP) @(negedge clk);
    chk("R8 single frame", got, 1);
    chk("R8 first byte kept", cap_data, 8'h55);
    chk("R8 not busy afterwards", tx_busy, 0);
    loop = 0;

    // R9 receive latency, plain frame of 10 bits
    set_cfg(6'b000000);
    c0 = cyc;
    send_rx(fbits(6'b000000, 8'hA5), 10);
    lo = (8 + 16 * 9) * D; hi = lo + D + 4;
    chk("R9 strobe count", got, 1);
    chk("R9 latency window", int'(cap_cyc - c0 >= lo && cap_cyc - c0 <= hi), 1);
    chk("R9 data", cap_data, 8'hA5);

    // R10 payload inversion on receive: line carries 3C, output is C3
    set_cfg(6'b100000);
    send_rx(fbits(6'b000000, 8'h3C), 10);
    chk("R10 complemented byte", cap_data, 8'hC3);

    // R11 inverted line
    set_cfg(6'b010000);
    send_rx(fbits(6'b010000, 8'h96), 10);
    chk("R11 inverted line byte", cap_data, 8'h96);
    chk("R11 no flags", {cap_pe, cap_fe}, 0);

    // R12 parity: line data 01 even -> parity bit must be 1; send 0
    set_cfg(6'b000100);
    fb = fbits(6'b000100, 8'h01); fb[9] = 1'b0;
    send_rx(fb, 11);
    chk("R12 parity error flagged", cap_pe, 1);
    chk("R12 no frame error", cap_fe, 0);
    set_cfg(6'b000110);
    send_rx(fbits(6'b000110, 8'h01), 11);
    chk("R12 odd parity accepted", cap_pe, 0);

    // R13 framing: stop low
    set_cfg(6'b000000);
    fb = fbits(6'b000000, 8'h77); fb[9] = 1'b0;
    send_rx(fb, 10);
    chk("R13 stop low flagged", cap_fe, 1);
    chk("R13 strobe count", got, 1);
    set_cfg(6'b000001);
    fb = fbits(6'b000001, 8'h77); fb[10] = 1'b0;
    send_rx(fb, 11);
    chk("R13 second stop low flagged", cap_fe, 1);

    // R14 short glitch rejected
    set_cfg(6'b000000);
    bench_rx = 0;
    repeat (3 * D) @(negedge clk);
    bench_rx = 1;
    repeat (14 * BP) @(negedge clk);
    chk("R14 glitch gives no byte", got, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule